// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block turns an asynchronous serial line into bytes (or 9-bit words) for a processor. A tick that runs at sixteen times the bit rate comes from outside. While the receiver is enabled it hunts for a falling edge on the line. It checks that the start bit is genuine, then samples every bit three times around its centre and takes a majority vote. Data arrive least significant bit first. When the stop position has been sampled, the word moves into a holding buffer that software reads.

Software sees a set of sticky flags: word ready, overrun, framing error, noise and idle line. Two request outputs combine these flags with their enables. All flags clear together through one sequence: a status read strobe, and then a later data read strobe. While an unread word sits in the buffer, any further word is discarded and marked as an overrun. A break (a frame that is low everywhere) is reported as a framing error. A gap with no traffic that lasts one whole frame is reported once as idle.

Top module: `serial_rx_flags`

## Requirements
- R1: While `rx_en` is low the line is ignored: no flag sets and no word is loaded. Raising `rx_en` starts the hunt for a start bit, and that hunt needs the line to be seen high on at least one tick first.
- R2: Bits are assembled least significant bit first. With `word9` high, nine data bits are received and the ninth appears on `rx_top_bit`. With `word9` low, eight are received and `rx_top_bit` is 0.
- R3: When the stop position of a frame is sampled and `flag_ready` is clear, the data word is copied to `rx_data`/`rx_top_bit` and `flag_ready` sets.
- R4: `irq_rx` is high exactly while `flag_ready` and `rx_irq_en` are both high.
- R5: Flags clear only when a `data_rd` strobe follows a `stat_rd` strobe given in an earlier cycle. A `data_rd` with no prior `stat_rd` changes nothing.
- R6: If a frame completes while `flag_ready` is set, `flag_overrun` sets and `rx_data`/`rx_top_bit` keep the unread word. Only the overrun flag changes.
- R7: A stop position sampled low sets `flag_framing` and still transfers the word. A break, where the line is low through the whole frame, gives word 0 with `flag_framing` set.
- R8: After enable, or after any completed frame, a line that stays high for one whole frame time (10 bit times with `word9` low, 11 with it high) while hunting sets `flag_idle` once. `irq_idle` equals `flag_idle` gated by `idle_irq_en`.
- R9: Each bit is sampled on oversampling phases 7, 8 and 9, where phase 0 is the tick on which the start edge is seen. The bit value is the majority of the three samples. Any disagreement, in the start, data or stop bits, sets `flag_noise` for that word.
- R10: A start bit whose majority vote is high is a false start: the receiver returns to hunting and nothing is reported.
- R11: `flag_overrun`, `flag_framing`, `flag_noise` and `flag_idle` clear through the same read sequence that clears `flag_ready`.
- R12: After a frame whose stop position was sampled low, no new start is accepted until the line has been seen high on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| stat_rd | input | 1 | Status read strobe (first step of the clear sequence) |
| data_rd | input | 1 | Data read strobe (second step of the clear sequence) |
| rx_irq_en | input | 1 | Enables the receive request |
| idle_irq_en | input | 1 | Enables the idle request |
| rx_data | output | 8 | Low eight bits of the buffered word |
| rx_top_bit | output | 1 | Ninth bit of the buffered word |
| flag_ready | output | 1 | Unread word present |
| flag_overrun | output | 1 | A word was lost because the buffer was full |
| flag_framing | output | 1 | Stop position sampled low |
| flag_noise | output | 1 | Samples within a bit disagreed |
| flag_idle | output | 1 | One whole idle frame seen |
| irq_rx | output | 1 | Receive request |
| irq_idle | output | 1 | Idle request |

## Verification
A wrong bit counter or phase counter shows up at the ports as a shifted or truncated `rx_data` in the frame where it occurs, because the stop decision then lands on a data bit. A stuck clear handshake shows up as `flag_ready` that never falls, or that falls on a lone data read, within three cycles of the strobes. A broken overrun block corrupts `rx_data` as soon as a second frame completes. A missing guard after a stop sampled low makes a held-low line report another break frame one frame time later.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned SRX_DW   = 8;
    localparam int unsigned SRX_WMAX = SRX_DW + 1;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [SRX_WMAX-1:0] word;
        logic                stop_low;
        logic                noisy;
    } rx_frame_t;

    typedef struct packed {
        logic ready;
        logic overrun;
        logic framing;
        logic noise;
        logic idle;
    } rx_flags_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

    function automatic int unsigned frame_bits(input logic nine);
        return SRX_DW + 2 + (nine ? 1 : 0);
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    input  logic tick,
    input  logic line,
    output logic vote_stb,
    output logic vote,
    output logic noisy,
    output logic bit_end
);
    import srx_pkg::*;

    localparam int unsigned PW = $clog2(OSR);
    localparam logic [PW-1:0] PH_A   = PW'(OSR/2 - 1);
    localparam logic [PW-1:0] PH_B   = PW'(OSR/2);
    localparam logic [PW-1:0] PH_C   = PW'(OSR/2 + 1);
    localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

    logic [PW-1:0] phase;
    logic          samp_a;
    logic          samp_b;
    logic          step;

    assign step = active & tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else begin
            if (restart) begin
                phase <= PW'(1);
            end else if (step) begin
                phase <= (phase == PH_END) ? '0 : phase + 1'b1;
            end
            if (step && phase == PH_A) samp_a <= line;
            if (step && phase == PH_B) samp_b <= line;
        end
    end

    assign vote_stb = step & (phase == PH_C);
    assign vote     = vote3(samp_a, samp_b, line);
    assign noisy    = split3(samp_a, samp_b, line);
    assign bit_end  = step & (phase == PH_END);

endmodule

// File: rtl/srx_frame.sv
module srx_frame #(
    parameter int unsigned OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                word9,
    input  logic                tick,
    input  logic                line,
    output logic                hunting,
    output logic                done,
    output srx_pkg::rx_frame_t  frame
);
    import srx_pkg::*;

    localparam int unsigned IW = $clog2(SRX_WMAX + 1);

    rx_state_e           st;
    logic                seen_high;
    logic [IW-1:0]       idx;
    logic [IW-1:0]       last_idx;
    logic [SRX_WMAX-1:0] shreg;
    logic                noise_acc;
    logic                start_seen;
    logic                vote_stb;
    logic                vote;
    logic                noisy;
    logic                bit_end;

    assign hunting    = (st == RX_HUNT);
    assign last_idx   = word9 ? IW'(SRX_DW) : IW'(SRX_DW - 1);
    assign start_seen = en & hunting & tick & ~line & seen_high;

    srx_sampler #(.OSR(OSR)) u_samp (
        .clk      (clk),
        .rst      (rst),
        .active   (en & ~hunting),
        .restart  (start_seen),
        .tick     (tick),
        .line     (line),
        .vote_stb (vote_stb),
        .vote     (vote),
        .noisy    (noisy),
        .bit_end  (bit_end)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st        <= RX_HUNT;
            seen_high <= 1'b0;
            idx       <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
            done      <= 1'b0;
            frame     <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_HUNT: begin
                    if (tick) begin
                        if (line) begin
                            seen_high <= 1'b1;
                        end else if (seen_high) begin
                            st        <= RX_START;
                            idx       <= '0;
                            shreg     <= '0;
                            noise_acc <= 1'b0;
                        end
                    end
                end
                RX_START: begin
                    if (vote_stb) begin
                        if (vote) st <= RX_HUNT;
                        else      noise_acc <= noisy;
                    end
                    if (bit_end) st <= RX_DATA;
                end
                RX_DATA: begin
                    if (vote_stb) begin
                        for (int i = 0; i < SRX_WMAX; i++) begin
                            if (idx == IW'(i)) shreg[i] <= vote;
                        end
                        noise_acc <= noise_acc | noisy;
                    end
                    if (bit_end) begin
                        if (idx == last_idx) st <= RX_STOP;
                        idx <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (vote_stb) begin
                        done           <= 1'b1;
                        frame.word     <= word9 ? shreg : {1'b0, shreg[SRX_DW-1:0]};
                        frame.stop_low <= ~vote;
                        frame.noisy    <= noise_acc | noisy;
                        seen_high      <= vote;
                        st             <= RX_HUNT;
                    end
                end
                default: st <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/srx_idle.sv
module srx_idle #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic word9,
    input  logic tick,
    input  logic line,
    input  logic hunting,
    input  logic frame_done,
    output logic idle_pulse
);
    import srx_pkg::*;

    localparam int unsigned CW = $clog2((SRX_WMAX + 2) * OSR + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] thresh;
    logic          armed;

    assign thresh = CW'(frame_bits(word9) * OSR - 1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed      <= 1'b1;
            cnt        <= '0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (frame_done) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (hunting && tick) begin
                if (!line) begin
                    cnt <= '0;
                end else if (armed) begin
                    if (cnt >= thresh) begin
                        idle_pulse <= 1'b1;
                        armed      <= 1'b0;
                        cnt        <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/srx_status.sv
module srx_status (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       done,
    input  srx_pkg::rx_frame_t         frame,
    input  logic                       idle_pulse,
    input  logic                       stat_rd,
    input  logic                       data_rd,
    output srx_pkg::rx_flags_t         flags,
    output logic [srx_pkg::SRX_WMAX-1:0] word_q
);
    import srx_pkg::*;

    rx_flags_t nxt;
    logic      clr_armed;
    logic      clearing;
    logic      take;

    assign clearing = data_rd & clr_armed;
    assign take     = en & done & ~(flags.ready & ~clearing);

    always_comb begin
        nxt = clearing ? '0 : flags;
        if (en && done) begin
            if (nxt.ready) begin
                nxt.overrun = 1'b1;
            end else begin
                nxt.ready   = 1'b1;
                nxt.framing = nxt.framing | frame.stop_low;
                nxt.noise   = nxt.noise | frame.noisy;
            end
        end
        if (en && idle_pulse) nxt.idle = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            word_q    <= '0;
            clr_armed <= 1'b0;
        end else begin
            flags <= nxt;
            if (take) word_q <= frame.word;
            if (stat_rd)      clr_armed <= 1'b1;
            else if (data_rd) clr_armed <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       word9,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic       stat_rd,
    input  logic       data_rd,
    input  logic       rx_irq_en,
    input  logic       idle_irq_en,
    output logic [7:0] rx_data,
    output logic       rx_top_bit,
    output logic       flag_ready,
    output logic       flag_overrun,
    output logic       flag_framing,
    output logic       flag_noise,
    output logic       flag_idle,
    output logic       irq_rx,
    output logic       irq_idle
);
    import srx_pkg::*;

    logic                hunting;
    logic                done;
    rx_frame_t           frame;
    logic                idle_pulse;
    rx_flags_t           flags;
    logic [SRX_WMAX-1:0] word_q;

    srx_frame #(.OSR(OSR)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .word9   (word9),
        .tick    (os_tick),
        .line    (rx_line),
        .hunting (hunting),
        .done    (done),
        .frame   (frame)
    );

    srx_idle #(.OSR(OSR)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .word9      (word9),
        .tick       (os_tick),
        .line       (rx_line),
        .hunting    (hunting),
        .frame_done (done),
        .idle_pulse (idle_pulse)
    );

    srx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .done       (done),
        .frame      (frame),
        .idle_pulse (idle_pulse),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .flags      (flags),
        .word_q     (word_q)
    );

    assign rx_data      = word_q[SRX_DW-1:0];
    assign rx_top_bit   = word_q[SRX_DW];
    assign flag_ready   = flags.ready;
    assign flag_overrun = flags.overrun;
    assign flag_framing = flags.framing;
    assign flag_noise   = flags.noise;
    assign flag_idle    = flags.idle;
    assign irq_rx       = flags.ready & rx_irq_en;
    assign irq_idle     = flags.idle & idle_irq_en;

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       data_rd,
    input logic       rx_irq_en,
    input logic       idle_irq_en,
    input logic [7:0] rx_data,
    input logic       rx_top_bit,
    input logic       flag_ready,
    input logic       flag_overrun,
    input logic       irq_rx,
    input logic       irq_idle
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !flag_ready) |=> !flag_ready); // R1

    AST_IRQ_RX_MASKED: assert property (@(posedge clk) disable iff (rst)
        !rx_irq_en |-> !irq_rx); // R4

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag_ready && !data_rd) |=> flag_ready); // R5

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_ready) |-> $past(data_rd)); // R5

    AST_BUFFER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (flag_ready && !data_rd) |=> ($stable(rx_data) && $stable(rx_top_bit))); // R6

    AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_overrun) |-> $past(flag_ready)); // R6

    AST_IRQ_IDLE_MASKED: assert property (@(posedge clk) disable iff (rst)
        !idle_irq_en |-> !irq_idle); // R8

endmodule

bind serial_rx_flags srx_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_en        (rx_en),
    .data_rd      (data_rd),
    .rx_irq_en    (rx_irq_en),
    .idle_irq_en  (idle_irq_en),
    .rx_data      (rx_data),
    .rx_top_bit   (rx_top_bit),
    .flag_ready   (flag_ready),
    .flag_overrun (flag_overrun),
    .irq_rx       (irq_rx),
    .irq_idle     (irq_idle)
);

// File: tb/serial_rx_flags_test.sv
`timescale 1ns/1ps
module serial_rx_flags_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       word9 = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       rx_irq_en = 1'b1;
    logic       idle_irq_en = 1'b1;
    logic [7:0] rx_data;
    logic       rx_top_bit;
    logic       flag_ready;
    logic       flag_overrun;
    logic       flag_framing;
    logic       flag_noise;
    logic       flag_idle;
    logic       irq_rx;
    logic       irq_idle;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 0;
    bit  auto_clear = 1;
    logic [10:0] exp_q[$];   // {framing, noise, top bit, data}

    serial_rx_flags uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .word9(word9), .os_tick(os_tick),
        .rx_line(rx_line), .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
        .rx_data(rx_data), .rx_top_bit(rx_top_bit), .flag_ready(flag_ready),
        .flag_overrun(flag_overrun), .flag_framing(flag_framing),
        .flag_noise(flag_noise), .flag_idle(flag_idle),
        .irq_rx(irq_rx), .irq_idle(irq_idle)
    );

    always #10 clk = ~clk;

    initial begin : tick_gen
        int div;
        div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            os_tick = (div == 0);
        end
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (os_tick !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic clear_seq();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) begin stat_rd = 1'b0; data_rd = 1'b1; end
        @(negedge clk) data_rd = 1'b0;
    endtask

    // driver: plays a frame tick by tick, glitch_t < 0 means no glitch
    task automatic send_frame(input logic [8:0] w, input bit push, input int glitch_t,
                              input bit exp_noise);
        int nb;
        logic [11:0] bits;
        nb = word9 ? 11 : 10;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < 9; i++) if (i < nb - 2) bits[i+1] = w[i];
        if (push) exp_q.push_back({1'b0, exp_noise, (word9 ? w[8] : 1'b0), w[7:0]});
        rx_line = 1'b1;
        wait_ticks(4);
        for (int t = 0; t < nb * 16; t++) begin
            rx_line = bits[t/16] ^ (t == glitch_t);
            wait_tick();
        end
        rx_line = 1'b1;
    endtask

    initial begin : monitor
        logic prev;
        logic [10:0] e;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && flag_ready && !prev) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R12 unexpected word: got %0h expected none", rx_data);
                end else begin
                    e = exp_q.pop_front();
                    check_eq("R2/R3", "word", {rx_top_bit, rx_data}, e[8:0]);
                    check_eq("R7", "framing", flag_framing, e[10]);
                    check_eq("R9", "noise", flag_noise, e[9]);
                    check_eq("R4", "irq_rx", irq_rx, rx_irq_en);
                end
                if (auto_clear) clear_seq();
            end
            prev = flag_ready;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R3", "reset ready", flag_ready, 0);
        check_eq("R6", "reset overrun", flag_overrun, 0);
        check_eq("R11", "reset other flags", {flag_framing, flag_noise, flag_idle}, 0);
        check_eq("R4", "reset irqs", {irq_rx, irq_idle}, 0);

        // R1: disabled receiver ignores a frame
        send_frame(9'h05A, 0, -1, 0);
        wait_ticks(10);
        check_eq("R1", "ready while disabled", flag_ready, 0);
        rx_en = 1'b1;
        wait_ticks(20);

        // R2 R3: 8-bit words
        send_frame(9'h0A5, 1, -1, 0);
        send_frame(9'h03C, 1, -1, 0);
        send_frame(9'h000, 1, -1, 0);
        send_frame(9'h0FF, 1, -1, 0);
        // R2: 9-bit words
        word9 = 1'b1;
        send_frame(9'h1C3, 1, -1, 0);
        send_frame(9'h055, 1, -1, 0);
        word9 = 1'b0;
        // R4: request masked
        rx_irq_en = 1'b0;
        send_frame(9'h081, 1, -1, 0);
        rx_irq_en = 1'b1;
        // R9: glitch on one sample of data bit 2, then on the start bit
        send_frame(9'h066, 1, 16*3 + 8, 1);
        send_frame(9'h099, 1, 7, 1);

        // R10: short low pulse is a false start
        wait_ticks(4);
        rx_line = 1'b0;
        wait_ticks(6);
        rx_line = 1'b1;
        wait_ticks(40);
        check_eq("R10", "ready after false start", flag_ready, 0);
        send_frame(9'h042, 1, -1, 0);

        // R7 R12: break then held low for two more frames
        exp_q.push_back({1'b1, 1'b0, 1'b0, 8'h00});
        wait_ticks(4);
        rx_line = 1'b0;
        wait_ticks(16 * 30);
        rx_line = 1'b1;
        wait_ticks(20);
        check_eq("R12", "queue drained after break", exp_q.size(), 0);
        send_frame(9'h024, 1, -1, 0);
        wait_ticks(8);

        // manual flag handling
        auto_clear = 0;
        send_frame(9'h011, 1, -1, 0);
        wait_ticks(4);
        check_eq("R3", "ready set", flag_ready, 1);
        check_eq("R4", "irq_rx with enable", irq_rx, 1);
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        @(negedge clk);
        check_eq("R5", "lone data read keeps ready", flag_ready, 1);
        send_frame(9'h022, 0, -1, 0);
        wait_ticks(4);
        check_eq("R6", "overrun set", flag_overrun, 1);
        check_eq("R6", "buffer kept", rx_data, 8'h11);
        clear_seq();
        @(negedge clk);
        check_eq("R5", "ready cleared", flag_ready, 0);
        check_eq("R11", "flags cleared", {flag_overrun, flag_framing, flag_noise, flag_idle}, 0);

        // R8: idle after a frame, once
        wait_ticks(200);
        check_eq("R8", "idle flag", flag_idle, 1);
        check_eq("R8", "idle request", irq_idle, 1);
        idle_irq_en = 1'b0;
        @(negedge clk);
        check_eq("R8", "idle request masked", irq_idle, 0);
        clear_seq();
        @(negedge clk);
        check_eq("R11", "idle cleared", flag_idle, 0);
        wait_ticks(200);
        check_eq("R8", "idle reported once", flag_idle, 0);
        check_eq("R3", "all expected words seen", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule